// File: doc/BRIEF.md
# Clock-Master Serial Word Receiver

This block receives serial words over a two-wire clocked link in which it owns the clock. A programmable divider paces a shift clock that the block drives out, and one data line is sampled once per clock period, on the high-to-low transition of the internal clock phase. A word is eight bits, least significant first. It can also be nine bits, in which case the extra bit lands in its own output. The clock rests at its idle level whenever no word is in progress. An inversion control flips that idle level and every edge that follows it.

Reception runs in one of two ways. The first arms a one-shot flag that receives a single word and then disarms itself. The second is a level enable that pulls in words back to back. When both are active, the level enable decides. Each completed word is moved to a holding register and raises a ready flag, and the ready flag can also drive an interrupt output. A read strobe consumes the word. If a word finishes while the previous one is still unread, the new word is dropped and an overrun error is latched. The overrun stops all reception until the continuous enable is taken away.

Top module: `syncRxMaster`

## Requirements
- R1: No shift-clock activity occurs unless `portEn` is high and either the one-shot flag `singleArm` or `contEn` is set.
- R2: Each shift-clock half period lasts exactly divider+1 clock cycles. With `clkInv`=0 the clock idles low, and data is sampled when the internal phase falls from high to low.
- R3: Bits arrive least significant first. The first sampled bit becomes `rxWord[0]` and the eighth becomes `rxWord[7]`.
- R4: A pulse on `singleStart` with `portEn` high sets `singleArm`. After one word with `contEn` low, `singleArm` returns to 0 and the clock stays idle.
- R5: While `contEn` is high, words follow one another with no further command. If `singleArm` and `contEn` are both set, reception keeps going beyond the first word.
- R6: With `nineBit`=1, the ninth sampled bit appears on `rxBit9`. With `nineBit`=0, `rxBit9` is 0.
- R7: `rxReady` rises only when a word completes, and a one-cycle `dataRead` pulse clears it. `rxIrq` equals `rxReady` gated by `intEn`.
- R8: With `clkInv`=1, `sclk` idles high and every edge is inverted.
- R9: With `wideDiv`=1 the divider is {`divHi`,`divLo`}. With `wideDiv`=0 only `divLo` is used and `divHi` has no effect.
- R10: A word that completes while `rxReady` is still set is discarded, so `rxWord` is unchanged. It sets `overrun` and halts the clock. `overrun` holds until `contEn` goes from 1 to 0.
- R11: Dropping `portEn` clears `singleArm` and ends any word in progress, and the clock returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Enables the port as clock master |
| singleStart | input | 1 | One-cycle pulse that arms a single-word receive |
| contEn | input | 1 | Continuous receive enable (level) |
| nineBit | input | 1 | Selects nine-bit words |
| clkInv | input | 1 | Inverts the shift-clock output |
| wideDiv | input | 1 | Selects the 16-bit divider instead of the 8-bit one |
| divHi | input | 8 | Divider high byte |
| divLo | input | 8 | Divider low byte |
| intEn | input | 1 | Receive interrupt enable |
| dataRead | input | 1 | One-cycle pulse that consumes the held word |
| rxData | input | 1 | Serial data in |
| sclk | output | 1 | Shift clock out |
| rxWord | output | 8 | Held received data |
| rxBit9 | output | 1 | Held ninth bit |
| rxReady | output | 1 | Word-ready flag |
| rxIrq | output | 1 | Receive interrupt |
| overrun | output | 1 | Overrun error flag |
| singleArm | output | 1 | One-shot receive flag state |

## Verification
The embedded properties check several rules on every cycle. The one-shot flag must disarm after a word when `contEn` is low, and continuous mode must restart after each completion. `rxReady` may only rise on a completion and must fall after a read, and sampling may only happen while the phase is high. An overrun must leave the held word untouched and must persist while `contEn` stays high. Other behaviour can only be shown by the bench's scenarios, which replay words against an independent bit model. These cover the data values and bit order, the half-period length for several divider settings and for the wide divider, the inverted polarity, the precedence of the two enables, and the stop-and-recover sequence around an overrun.

// File: rtl/syncRxPkg.sv
package syncRxPkg;
  // Strobes issued by the sequencing logic to the data path
  typedef struct packed {
    logic shiftEn;   // sample the data line this cycle
    logic wordDone;  // last bit of the word sampled this cycle
  } rxStrobeT;
endpackage

// File: rtl/syncRxCtrl.sv
module syncRxCtrl
  import syncRxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              singleStart,
  input  logic              contEn,
  input  logic              nineBit,
  input  logic              wideDiv,
  input  logic [BYTE_W-1:0] divHi,
  input  logic [BYTE_W-1:0] divLo,
  input  logic              holdBusy,
  input  logic              overrun,
  output rxStrobeT          strobe,
  output logic              phase,
  output logic              singleArm
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST8 = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST9 = IDX_W'(DATA_W);

  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divVal;
  logic [IDX_W-1:0] bitIdx;
  logic             runOk;
  logic             tick;
  logic             lastBit;

  assign divVal  = wideDiv ? {divHi, divLo} : {{BYTE_W{1'b0}}, divLo};
  assign runOk   = portEn && (contEn || singleArm) && !overrun;
  assign tick    = active && runOk && (cnt == divVal);
  assign lastBit = nineBit ? (bitIdx == LAST9) : (bitIdx == LAST8);

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = tick && phase;
    strobe.wordDone = tick && phase && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleArm <= 1'b0;
    end else if (!portEn) begin
      singleArm <= 1'b0;
    end else if (singleStart) begin
      singleArm <= 1'b1;
    end else if (strobe.wordDone && !contEn) begin
      singleArm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!active) begin
      cnt    <= '0;
      phase  <= 1'b0;
      bitIdx <= '0;
      if (runOk) active <= 1'b1;
    end else if (!runOk) begin
      active <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= !phase;
      if (phase) begin
        if (lastBit) begin
          bitIdx <= '0;
          if (!(contEn && !holdBusy)) active <= 1'b0;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the one-shot flag disarms after its word when continuous mode is off
  a_r4_single_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordDone && !contEn && !singleStart |=> !singleArm);

  // R5: continuous mode starts the next word at once when the holder is free
  a_r5_cont_continues: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordDone && contEn && portEn && !holdBusy && !overrun |=> active);

  // R2: sampling happens only on the high-to-low transition of the phase
  a_r2_sample_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !phase);
endmodule

// File: rtl/syncRxDatapath.sv
module syncRxDatapath
  import syncRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxData,
  input  logic              nineBit,
  input  logic              contEn,
  input  logic              dataRead,
  input  rxStrobeT          strobe,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxBit9,
  output logic              rxReady,
  output logic              overrun,
  output logic              holdBusy
);
  logic [DATA_W:0] shReg;
  logic [DATA_W:0] shNext;
  logic            contEnD;

  assign shNext   = {rxData, shReg[DATA_W:1]};
  assign holdBusy = rxReady && !dataRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.shiftEn) begin
      shReg <= shNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord  <= '0;
      rxBit9  <= 1'b0;
      rxReady <= 1'b0;
    end else if (strobe.wordDone && !holdBusy) begin
      rxWord  <= nineBit ? shNext[DATA_W-1:0] : shNext[DATA_W:1];
      rxBit9  <= nineBit ? shNext[DATA_W] : 1'b0;
      rxReady <= 1'b1;
    end else if (dataRead) begin
      rxReady <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
      contEnD <= 1'b0;
    end else begin
      contEnD <= contEn;
      if (contEnD && !contEn) overrun <= 1'b0;
      else if (strobe.wordDone && holdBusy) overrun <= 1'b1;
    end
  end

  // R7: the ready flag rises only as a word completes
  a_r7_ready_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(strobe.wordDone));

  // R7: a read with no simultaneous completion empties the holder
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    dataRead && !strobe.wordDone |=> !rxReady);

  // R10: a word arriving into a full holder is dropped
  a_r10_discard: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordDone && holdBusy |=> $stable(rxWord) && overrun);

  // R10: the error persists while the continuous enable stays high
  a_r10_overrun_holds: assert property (@(posedge clk) disable iff (!rstN)
    overrun && contEn |=> overrun);
endmodule

// File: rtl/syncRxMaster.sv
module syncRxMaster
  import syncRxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              singleStart,
  input  logic              contEn,
  input  logic              nineBit,
  input  logic              clkInv,
  input  logic              wideDiv,
  input  logic [BYTE_W-1:0] divHi,
  input  logic [BYTE_W-1:0] divLo,
  input  logic              intEn,
  input  logic              dataRead,
  input  logic              rxData,
  output logic              sclk,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxBit9,
  output logic              rxReady,
  output logic              rxIrq,
  output logic              overrun,
  output logic              singleArm
);
  rxStrobeT strobe;
  logic     phase;
  logic     holdBusy;

  syncRxCtrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .singleStart(singleStart),
    .contEn(contEn), .nineBit(nineBit), .wideDiv(wideDiv), .divHi(divHi),
    .divLo(divLo), .holdBusy(holdBusy), .overrun(overrun), .strobe(strobe),
    .phase(phase), .singleArm(singleArm)
  );

  syncRxDatapath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .rxData(rxData), .nineBit(nineBit),
    .contEn(contEn), .dataRead(dataRead), .strobe(strobe), .rxWord(rxWord),
    .rxBit9(rxBit9), .rxReady(rxReady), .overrun(overrun), .holdBusy(holdBusy)
  );

  assign sclk  = phase ^ clkInv;
  assign rxIrq = rxReady && intEn;

  // R1: the clock stays at idle while the port is disabled
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> sclk == clkInv);
endmodule

// File: tb/syncRxMaster_test.sv
module syncRxMaster_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic portEn = 0, singleStart = 0, contEn = 0, nineBit = 0, clkInv = 0;
  logic wideDiv = 0, intEn = 0, dataRead = 0, rxData = 0;
  logic [7:0] divHi = 8'h00, divLo = 8'h00;
  logic sclk, rxBit9, rxReady, rxIrq, overrun, singleArm;
  logic [7:0] rxWord;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  logic [8:0] txWords [4];
  logic drvClear = 0;
  int bitPtr = 0, wordPtr = 0, highCnt = 0, lastHigh = 0, riseCnt = 0;
  logic prevPh = 0;

  always #5 clk = ~clk;

  syncRxMaster uut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .singleStart(singleStart),
    .contEn(contEn), .nineBit(nineBit), .clkInv(clkInv), .wideDiv(wideDiv),
    .divHi(divHi), .divLo(divLo), .intEn(intEn), .dataRead(dataRead),
    .rxData(rxData), .sclk(sclk), .rxWord(rxWord), .rxBit9(rxBit9),
    .rxReady(rxReady), .rxIrq(rxIrq), .overrun(overrun), .singleArm(singleArm)
  );

  // Bit model: present the next bit when the phase rises, measure high time
  always @(negedge clk) begin
    logic ph;
    ph = sclk ^ clkInv;
    if (drvClear) begin
      bitPtr = 0; wordPtr = 0; highCnt = 0;
    end else begin
      if (ph && !prevPh) begin
        riseCnt++;
        rxData = txWords[wordPtr % 4][bitPtr];
        if (bitPtr == (nineBit ? 8 : 7)) begin bitPtr = 0; wordPtr++; end
        else bitPtr++;
      end
      if (ph) highCnt++;
      else if (prevPh) begin lastHigh = highCnt; highCnt = 0; end
    end
    prevPh = ph;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearDriver();
    drvClear = 1; step(); drvClear = 0;
  endtask

  task automatic pulseSingle();
    singleStart = 1; step(); singleStart = 0;
  endtask

  task automatic readWord();
    dataRead = 1; step(); dataRead = 0;
  endtask

  task automatic waitReady(input string tag, input int lim);
    int n = 0;
    while (!rxReady && n < lim) begin step(); n++; end
    chk(tag, int'(rxReady), 1);
  endtask

  function automatic logic [8:0] pat(input int p);
    case (p)
      0: return 9'h0A5;
      1: return 9'h15A;
      2: return 9'h1FF;
      default: return 9'h001;
    endcase
  endfunction

  initial begin
    int d, r, lim;
    repeat (3) step();
    rstN = 1;
    step();
    // reset state
    chk("R2 reset sclk idle low", int'(sclk), 0);
    chk("R7 reset ready", int'(rxReady), 0);
    chk("R10 reset overrun", int'(overrun), 0);
    chk("R7 reset irq", int'(rxIrq), 0);

    // R1 / R11: no activity when the port is disabled
    r = riseCnt;
    pulseSingle();
    repeat (30) step();
    chk("R11 arm ignored when port off", int'(singleArm), 0);
    chk("R1 no clock when port off", riseCnt - r, 0);
    portEn = 1;
    repeat (20) step();
    chk("R1 no clock without an enable", riseCnt - r, 0);

    // single-word sweep over divider, word length and patterns
    divHi = 8'hFF;  // R9: ignored with the narrow divider
    for (int di = 0; di < 4; di++) begin
      d = (di == 3) ? 5 : di;
      for (int nb = 0; nb < 2; nb++) begin
        for (int p = 0; p < 4; p++) begin
          divLo = 8'(d); nineBit = nb[0]; intEn = nb[0];
          txWords[0] = pat(p);
          clearDriver();
          pulseSingle();
          lim = 40 * (d + 1) + 50;
          waitReady("R4 single word completes", lim);
          step();
          chk("R3 data lsb first", int'(rxWord), int'(pat(p) & 9'h0FF));
          chk("R6 ninth bit", int'(rxBit9), nb ? int'(pat(p) >> 8) : 0);
          chk("R9 narrow divider half period", lastHigh, d + 1);
          chk("R4 single flag cleared", int'(singleArm), 0);
          chk("R7 irq follows enable", int'(rxIrq), nb);
          r = riseCnt;
          repeat (4 * (d + 1) + 8) step();
          chk("R4 clock stopped after word", riseCnt - r, 0);
          chk("R2 idle low after word", int'(sclk), 0);
          readWord();
          chk("R7 read clears ready", int'(rxReady), 0);
          chk("R7 irq drops after read", int'(rxIrq), 0);
        end
      end
    end
    intEn = 0;

    // R9: wide divider
    wideDiv = 1; divHi = 8'h01; divLo = 8'h00; nineBit = 0;
    txWords[0] = 9'h03C;
    clearDriver();
    pulseSingle();
    waitReady("R9 wide divider word completes", 6000);
    step();
    chk("R9 wide divider half period", lastHigh, 257);
    chk("R9 wide divider data", int'(rxWord), 8'h3C);
    readWord();
    wideDiv = 0; divHi = 8'h00; divLo = 8'h01;

    // R8: inverted clock
    clkInv = 1;
    step();
    chk("R8 inverted idle high", int'(sclk), 1);
    txWords[0] = 9'h0C3;
    clearDriver();
    pulseSingle();
    waitReady("R8 inverted word completes", 200);
    step();
    chk("R8 inverted data", int'(rxWord), 8'hC3);
    chk("R8 inverted half period", lastHigh, 2);
    chk("R8 inverted idle after word", int'(sclk), 1);
    readWord();
    clkInv = 0;
    step();

    // R5: both enables, continuous wins
    txWords[0] = 9'h011; txWords[1] = 9'h022; txWords[2] = 9'h033;
    clearDriver();
    contEn = 1;
    pulseSingle();
    waitReady("R5 first word", 200);
    chk("R5 first data", int'(rxWord), 8'h11);
    readWord();
    waitReady("R5 second word arrives", 200);
    chk("R5 second data", int'(rxWord), 8'h22);
    chk("R5 single flag kept under continuous", int'(singleArm), 1);
    readWord();
    contEn = 0;
    waitReady("R4 trailing single word", 200);
    step();
    chk("R4 trailing data", int'(rxWord), 8'h33);
    chk("R4 flag cleared after trailing word", int'(singleArm), 0);
    readWord();

    // R10: overrun
    txWords[0] = 9'h0A1; txWords[1] = 9'h0B2; txWords[2] = 9'h0C3;
    clearDriver();
    contEn = 1;
    waitReady("R5 continuous word 0", 200);
    readWord();
    waitReady("R5 continuous word 1", 200);
    begin
      int n = 0;
      while (!overrun && n < 200) begin step(); n++; end
    end
    chk("R10 overrun set", int'(overrun), 1);
    chk("R10 new word discarded", int'(rxWord), 8'hB2);
    chk("R10 ready still set", int'(rxReady), 1);
    r = riseCnt;
    repeat (40) step();
    chk("R10 reception halted", riseCnt - r, 0);
    chk("R10 overrun persists", int'(overrun), 1);
    contEn = 0;
    step(); step();
    chk("R10 cleared by dropping continuous", int'(overrun), 0);
    readWord();

    // R11: dropping the port mid-word
    txWords[0] = 9'h0FF;
    clearDriver();
    pulseSingle();
    repeat (9) step();
    portEn = 0;
    step(); step();
    chk("R11 flag cleared by port off", int'(singleArm), 0);
    chk("R11 clock idle after abort", int'(sclk), 0);
    r = riseCnt;
    repeat (30) step();
    chk("R11 no further clocks", riseCnt - r, 0);
    chk("R11 no word delivered", int'(rxReady), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule